// File: doc/BRIEF.md
# Two-Requester Bus Tenure Arbiter

This block hands one shared data bus to one of two clients: a frame transmit engine and a frame receive engine. Each client raises a request, gets back a grant, and can end its turn early with a done pulse. A grant is held for a bounded number of clock cycles, called the quantum. Each side has its own 8-bit quantum input. The quantum is captured at the moment the grant begins.

When a holder's quantum runs out and the other side is waiting, the holder is preempted. Both grants then stay low for one dead cycle before the other side is granted. If nobody else is waiting, the holder keeps the bus and a fresh quantum starts.

When both sides ask at the same moment, the side that did not hold the bus last wins. After reset, receive is treated as the preferred side, so it wins the first tie.

Top module: `bus_tenure_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, both grants are low.
- R2: The two grants are never high in the same cycle.
- R3: From idle, a single request is granted in the clock cycle after the request is seen.
- R4: On a tie right after reset, receive is granted first.
- R5: A contested holder keeps its grant for exactly its quantum in cycles, then loses it.
- R6: Every release is followed by exactly one cycle with both grants low. The waiting side's grant rises in the cycle after that.
- R7: A holder whose peer is not requesting keeps its grant past its quantum.
- R8: Done from the holder drops its grant in the next cycle.
- R9: A holder that lowers its request loses its grant in the next cycle, exactly as with done.
- R10: On a tie, the side that held the bus last loses. This overrides the receive preference.
- R11: A quantum of 0 gives a tenure of one cycle.
- R12: The quantum is captured when the grant starts. Changing the input during a tenure does not change that tenure's length.
- R13: Done from the side that is not holding the bus has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_req | input | 1 | Transmit engine requests the bus |
| tx_done | input | 1 | Transmit engine ends its tenure |
| tx_quantum | input | QW | Transmit tenure length in cycles (0 is read as 1) |
| rx_req | input | 1 | Receive engine requests the bus |
| rx_done | input | 1 | Receive engine ends its tenure |
| rx_quantum | input | QW | Receive tenure length in cycles (0 is read as 1) |
| tx_grant | output | 1 | Bus granted to the transmit engine |
| rx_grant | output | 1 | Bus granted to the receive engine |

## Verification
The hardest case to reach is a preemption whose length depends on a captured quantum while the quantum input changes in the middle of the tenure. The bench keeps both requests high so the tenure is contested. It loads a quantum of 5 when the receive grant starts, then writes 1 into the quantum input one cycle later. The receive grant must still last five cycles. The alternation rule is reached the same way: a tie is set up directly after each side's release, so that the previous holder must lose.

// File: rtl/bus_tenure_arbiter.sv
module bus_tenure_arbiter #(
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_req,
  input  logic          tx_done,
  input  logic [QW-1:0] tx_quantum,
  input  logic          rx_req,
  input  logic          rx_done,
  input  logic [QW-1:0] rx_quantum,
  output logic          tx_grant,
  output logic          rx_grant
);

  localparam logic [QW-1:0] ONE = QW'(1);

  typedef enum logic [1:0] {IDLE, OWN_TX, OWN_RX} st_t;

  st_t           st, st_nx;
  logic          last_rx, last_rx_nx;
  logic [QW-1:0] cnt, cnt_nx;

  wire [QW-1:0] tx_len  = (tx_quantum == '0) ? ONE : tx_quantum;
  wire [QW-1:0] rx_len  = (rx_quantum == '0) ? ONE : rx_quantum;
  wire          tx_quit = !tx_req || tx_done;
  wire          rx_quit = !rx_req || rx_done;
  wire          pick_rx = rx_req && (!tx_req || !last_rx);
  wire          expired = (cnt == ONE);

  always_comb begin
    st_nx      = st;
    last_rx_nx = last_rx;
    cnt_nx     = cnt;
    case (st)
      IDLE: begin
        if (pick_rx) begin
          st_nx  = OWN_RX;
          cnt_nx = rx_len;
        end else if (tx_req) begin
          st_nx  = OWN_TX;
          cnt_nx = tx_len;
        end
      end
      OWN_TX: begin
        if (tx_quit || (expired && rx_req)) begin
          st_nx      = IDLE;
          last_rx_nx = 1'b0;
        end else if (expired) begin
          cnt_nx = tx_len;
        end else begin
          cnt_nx = cnt - ONE;
        end
      end
      OWN_RX: begin
        if (rx_quit || (expired && tx_req)) begin
          st_nx      = IDLE;
          last_rx_nx = 1'b1;
        end else if (expired) begin
          cnt_nx = rx_len;
        end else begin
          cnt_nx = cnt - ONE;
        end
      end
      default: st_nx = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      last_rx <= 1'b0;
      cnt     <= '0;
    end else begin
      st      <= st_nx;
      last_rx <= last_rx_nx;
      cnt     <= cnt_nx;
    end
  end

  assign tx_grant = (st == OWN_TX);
  assign rx_grant = (st == OWN_RX);

  assert_idle_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_grant && !rx_grant && (tx_req || rx_req)) |=> (tx_grant || rx_grant));

  assert_dead_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_grant) |-> !$past(tx_grant));

  assert_dead_cycle_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_grant) |-> !$past(rx_grant));

  assert_keep_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_grant && tx_req && !tx_done && !rx_req) |=> tx_grant);

  assert_early_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_grant && rx_done) |=> !rx_grant);

  assert_req_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_grant && !tx_req) |=> !tx_grant);

  assert_tenure_live_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_grant || rx_grant) |-> (cnt != '0));

endmodule

// File: tb/bus_tenure_arbiter_test.sv
module bus_tenure_arbiter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_req = 1'b0, tx_done = 1'b0, rx_req = 1'b0, rx_done = 1'b0;
  logic [7:0] tq = 8'd3, rq = 8'd2;
  logic       tx_grant, rx_grant;

  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 1'b0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  bus_tenure_arbiter #(.QW(8)) uut (
    .clk(clk), .rst_n(rst_n),
    .tx_req(tx_req), .tx_done(tx_done), .tx_quantum(tq),
    .rx_req(rx_req), .rx_done(rx_done), .rx_quantum(rq),
    .tx_grant(tx_grant), .rx_grant(rx_grant)
  );

  // inputs for this cycle, expected grants {tx,rx} for this cycle
  task automatic step(input logic tr, input logic td, input logic rr, input logic rd,
                      input logic etx, input logic erx, input string tag);
    @(posedge clk);
    #1;
    tx_req = tr; tx_done = td; rx_req = rr; rx_done = rd;
    exp_q.push_back({etx, erx});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (tx_grant && rx_grant) begin
      vectors++;
      miscompares++;
      $display("FAIL R2: got tx=%b rx=%b expected never both", tx_grant, rx_grant);
    end
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if ({tx_grant, rx_grant} !== e) begin
        miscompares++;
        $display("FAIL %s: got tx/rx=%b%b expected %b%b", t, tx_grant, rx_grant, e[1], e[0]);
      end
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    step(0,0,0,0, 0,0, "R1");
    step(0,0,0,0, 0,0, "R1");
    rst_n = 1'b1;
    // contested ties: receive first, then alternation
    step(1,0,1,0, 0,0, "R1");
    step(1,0,1,0, 0,1, "R4");
    step(1,0,1,0, 0,1, "R5");
    step(1,0,1,0, 0,0, "R6");
    step(1,0,1,0, 1,0, "R10");
    step(1,0,1,0, 1,0, "R5");
    step(1,0,1,0, 1,0, "R5");
    step(1,0,1,0, 0,0, "R6");
    step(0,0,1,1, 0,1, "R10");
    step(0,0,0,0, 0,0, "R8");
    // lone transmit holder, then request drop
    tq = 8'd2;
    step(1,0,0,0, 0,0, "R3");
    step(1,0,0,0, 1,0, "R3");
    for (int i = 0; i < 4; i++) step(1,0,0,0, 1,0, "R7");
    step(0,0,0,0, 1,0, "R7");
    step(0,0,0,0, 0,0, "R9");
    // zero quantum and captured quantum
    tq = 8'd0; rq = 8'd5;
    step(1,0,0,0, 0,0, "R3");
    step(1,0,1,0, 1,0, "R11");
    step(1,0,1,0, 0,0, "R11");
    step(1,0,1,0, 0,1, "R12");
    rq = 8'd1;
    for (int i = 0; i < 4; i++) step(1,0,1,0, 0,1, "R12");
    step(1,0,1,0, 0,0, "R6");
    step(1,0,0,1, 1,0, "R10");
    step(1,0,0,0, 1,0, "R13");
    step(1,1,0,0, 1,0, "R13");
    step(0,0,0,0, 0,0, "R8");
    step(0,0,0,0, 0,0, "R1");
    @(posedge clk);
    @(posedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule